// File: doc/BRIEF.md
# Configurable Width Stack Pointer

This block sequences the stack traffic of a small processor core. It holds the stack pointer and turns requests into single-byte memory writes and reads. The supported requests are a one-byte push, a one-byte pop, a subroutine call, interrupt entry, a subroutine return and an interrupt return. A mode input selects the pointer width. In wide mode the pointer is sixteen bits and covers the whole RAM address space. In narrow mode only the low byte moves, the stack is held to the first 256-byte bank, and the high byte is a general-purpose user register.

A push lowers the pointer and then writes the byte at the new address. A pop reads the byte at the pointer and then raises it. The pointer therefore always addresses the lowest occupied byte. Multi-byte requests run one byte per clock. Software-style direct writes to either pointer byte take priority over the sequencer. The RAM itself sits outside the block and is synchronous, with one cycle of read latency.

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset, `sp_lo` and `sp_hi` are 0, `busy` is 0, and `mem_we`, `mem_re`, `stk_wrap`, `pop_valid` and `ret_valid` are 0.
- R2: A push first decrements the pointer, then writes its byte at the new pointer value, so the pointer ends up addressing the most recently written byte.
- R3: A pop reads at the current pointer and then increments it. RAM data is sampled on `mem_rd_data` in the cycle after `mem_re`, and it appears on `pop_data` with `pop_valid` one cycle later.
- R4: A call pushes the PC low byte and then the PC high byte, which leaves the high byte on top. A return pops the high byte, then the low byte, and presents the result on `ret_pc` with a one-cycle `ret_valid` pulse and `ret_irq`=0.
- R5: Interrupt entry pushes the PC low byte, the PC high byte and then the flags byte, one byte per cycle. An interrupt return pops flags, PC high and PC low, and raises `ret_valid` with `ret_irq`=1 and the flags on `ret_flags`.
- R6: With `wide_mode`=0, only `sp_lo` moves on stack operations. It wraps modulo 256, and every stack address has its upper byte at zero. `sp_hi` changes only through a direct high-byte write.
- R7: With `wide_mode`=1, the pointer is a 16-bit value `{sp_hi, sp_lo}`, and a decrement borrows into `sp_hi`.
- R8: `stk_wrap` pulses for one cycle, together with the memory strobe, whenever a step wraps the pointer. In narrow mode this is a push from low byte 00h or a pop from FFh. In wide mode it is a push from 0000h or a pop from FFFFh.
- R9: A direct pointer write (`reg_wr_lo`/`reg_wr_hi`) is applied, and any stack request presented in the same cycle is discarded, with no memory strobe in the next cycle.
- R10: When idle, at most one request is accepted per cycle, with priority interrupt > call > return > interrupt return > push > pop. Requests arriving while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 16-bit pointer, 0 = 8-bit pointer in bank 0 |
| push_req | input | 1 | Push one data byte |
| push_data | input | DATA_W | Byte to push |
| pop_req | input | 1 | Pop one data byte |
| call_req | input | 1 | Push PC for a call |
| irq_req | input | 1 | Push PC and flags for interrupt entry |
| ret_req | input | 1 | Pop PC for a return |
| iret_req | input | 1 | Pop flags and PC for an interrupt return |
| pc_in | input | 2*DATA_W | Program counter to save |
| flags_in | input | DATA_W | Flags byte to save |
| reg_wr_lo | input | 1 | Direct write of the pointer low byte |
| reg_wr_hi | input | 1 | Direct write of the pointer high / user byte |
| reg_wdata | input | DATA_W | Data for direct writes |
| mem_rd_data | input | DATA_W | RAM read data, one cycle after `mem_re` |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | 2*DATA_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| stk_wrap | output | 1 | Pointer wrapped on this step |
| busy | output | 1 | A multi-step request is in progress |
| sp_lo | output | DATA_W | Pointer low byte |
| sp_hi | output | DATA_W | Pointer high byte or user register |
| pop_valid | output | 1 | `pop_data` holds a popped byte |
| pop_data | output | DATA_W | Popped data byte |
| ret_valid | output | 1 | `ret_pc` holds a restored program counter |
| ret_irq | output | 1 | The return was an interrupt return |
| ret_flags | output | DATA_W | Restored flags (interrupt return) |
| ret_pc | output | 2*DATA_W | Restored program counter |

## Verification
The assertions check several properties on every cycle. Each write strobe must land exactly at the current pointer, and each read strobe must sit one below it. Narrow-mode addresses must stay inside bank 0, and the high byte must stay put in narrow mode. Wide-mode decrements must borrow correctly, a direct write must suppress the next memory strobe, and `ret_valid` must never pulse on two cycles in a row. Other behaviours only the bench scenarios can show. These are the byte ordering of calls and interrupt entry against returns, the values restored from RAM, the wrap pulses at both pointer widths, the request priority, and the discarding of a request that collides with a direct write.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PUSH, OP_POP, OP_CALL, OP_IRQ, OP_RET, OP_IRET
  } op_e;

  typedef enum logic [2:0] {
    DST_NONE, DST_DATA, DST_FLG, DST_PCH, DST_PCL
  } dst_e;

  typedef struct packed {
    logic irq;
    dst_e dst;
  } tag_t;
endpackage

// File: rtl/stkp_seq.sv
module stkp_seq
  import stkp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_req,
  input  logic                pop_req,
  input  logic                call_req,
  input  logic                irq_req,
  input  logic                ret_req,
  input  logic                iret_req,
  input  logic                hold,
  input  logic [DATA_W-1:0]   push_data,
  input  logic [DATA_W-1:0]   flags_in,
  input  logic [2*DATA_W-1:0] pc_in,
  output logic                busy,
  output logic                step_push,
  output logic                step_pop,
  output logic [DATA_W-1:0]   step_byte,
  output tag_t                step_tag
);
  localparam int PC_W = 2 * DATA_W;

  op_e               op_q, op_pick;
  logic [1:0]        step_q, last_step;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] flg_q, dat_q;
  logic              accept, adv, is_push_op, is_pop_op;

  always_comb begin
    if (irq_req)       op_pick = OP_IRQ;
    else if (call_req) op_pick = OP_CALL;
    else if (ret_req)  op_pick = OP_RET;
    else if (iret_req) op_pick = OP_IRET;
    else if (push_req) op_pick = OP_PUSH;
    else if (pop_req)  op_pick = OP_POP;
    else               op_pick = OP_IDLE;
  end

  assign busy       = (op_q != OP_IDLE);
  assign accept     = !busy && !hold && (op_pick != OP_IDLE);
  assign adv        = busy && !hold;
  assign is_push_op = (op_q == OP_PUSH) || (op_q == OP_CALL) || (op_q == OP_IRQ);
  assign is_pop_op  = (op_q == OP_POP) || (op_q == OP_RET) || (op_q == OP_IRET);
  assign step_push  = adv && is_push_op;
  assign step_pop   = adv && is_pop_op;

  always_comb begin
    case (op_q)
      OP_CALL, OP_RET:  last_step = 2'd1;
      OP_IRQ, OP_IRET:  last_step = 2'd2;
      default:          last_step = 2'd0;
    endcase
  end

  always_comb begin
    step_byte = dat_q;
    case (op_q)
      OP_CALL: step_byte = (step_q == 2'd0) ? pc_q[DATA_W-1:0] : pc_q[PC_W-1:DATA_W];
      OP_IRQ: begin
        if (step_q == 2'd0)      step_byte = pc_q[DATA_W-1:0];
        else if (step_q == 2'd1) step_byte = pc_q[PC_W-1:DATA_W];
        else                     step_byte = flg_q;
      end
      default: step_byte = dat_q;
    endcase
  end

  always_comb begin
    step_tag = '{irq: 1'b0, dst: DST_NONE};
    case (op_q)
      OP_POP: step_tag.dst = DST_DATA;
      OP_RET: step_tag.dst = (step_q == 2'd0) ? DST_PCH : DST_PCL;
      OP_IRET: begin
        step_tag.irq = 1'b1;
        if (step_q == 2'd0)      step_tag.dst = DST_FLG;
        else if (step_q == 2'd1) step_tag.dst = DST_PCH;
        else                     step_tag.dst = DST_PCL;
      end
      default: step_tag.dst = DST_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      step_q <= 2'd0;
      pc_q   <= '0;
      flg_q  <= '0;
      dat_q  <= '0;
    end else if (accept) begin
      op_q   <= op_pick;
      step_q <= 2'd0;
      pc_q   <= pc_in;
      flg_q  <= flags_in;
      dat_q  <= push_data;
    end else if (adv) begin
      if (step_q == last_step) begin
        op_q   <= OP_IDLE;
        step_q <= 2'd0;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  // R10
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step_q <= last_step));
endmodule

// File: rtl/stkp_ptr.sv
module stkp_ptr #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic                step_push,
  input  logic                step_pop,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   sp_lo,
  output logic [DATA_W-1:0]   sp_hi,
  output logic [2*DATA_W-1:0] push_addr,
  output logic [2*DATA_W-1:0] pop_addr,
  output logic                wrap_push,
  output logic                wrap_pop
);
  localparam int SP_W = 2 * DATA_W;

  logic [SP_W-1:0]   sp_q, full_dec, full_inc;
  logic [DATA_W-1:0] lo_dec, lo_inc;

  assign sp_lo    = sp_q[DATA_W-1:0];
  assign sp_hi    = sp_q[SP_W-1:DATA_W];
  assign full_dec = sp_q - SP_W'(1);
  assign full_inc = sp_q + SP_W'(1);
  assign lo_dec   = sp_lo - DATA_W'(1);
  assign lo_inc   = sp_lo + DATA_W'(1);

  assign push_addr = wide_mode ? full_dec : {{DATA_W{1'b0}}, lo_dec};
  assign pop_addr  = wide_mode ? sp_q     : {{DATA_W{1'b0}}, sp_lo};
  assign wrap_push = wide_mode ? (sp_q == '0) : (sp_lo == '0);
  assign wrap_pop  = wide_mode ? (&sp_q)      : (&sp_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) sp_q[DATA_W-1:0]    <= wdata;
      if (wr_hi) sp_q[SP_W-1:DATA_W] <= wdata;
    end else if (step_push) begin
      if (wide_mode) sp_q <= full_dec;
      else           sp_q[DATA_W-1:0] <= lo_dec;
    end else if (step_pop) begin
      if (wide_mode) sp_q <= full_inc;
      else           sp_q[DATA_W-1:0] <= lo_inc;
    end
  end

  // R6
  sph_user_chk: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && !wr_hi) |=> $stable(sp_hi));

  // R7
  borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && step_push && !wr_lo && !wr_hi && (sp_lo == '0) && (sp_hi != '0))
      |=> (sp_hi == DATA_W'($past(sp_hi) - DATA_W'(1))));
endmodule

// File: rtl/stkp_ret.sv
module stkp_ret
  import stkp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  tag_t                tag_in,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                pop_valid,
  output logic [DATA_W-1:0]   pop_data,
  output logic                ret_valid,
  output logic                ret_irq,
  output logic [DATA_W-1:0]   ret_flags,
  output logic [2*DATA_W-1:0] ret_pc
);
  tag_t              tag_q;
  logic [DATA_W-1:0] pch_q, flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q     <= '{irq: 1'b0, dst: DST_NONE};
      pch_q     <= '0;
      flg_q     <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
      ret_valid <= 1'b0;
      ret_irq   <= 1'b0;
      ret_flags <= '0;
      ret_pc    <= '0;
    end else begin
      tag_q     <= tag_in;
      pop_valid <= 1'b0;
      ret_valid <= 1'b0;
      case (tag_q.dst)
        DST_DATA: begin
          pop_data  <= rd_data;
          pop_valid <= 1'b1;
        end
        DST_FLG: flg_q <= rd_data;
        DST_PCH: pch_q <= rd_data;
        DST_PCL: begin
          ret_pc    <= {pch_q, rd_data};
          ret_flags <= tag_q.irq ? flg_q : '0;
          ret_irq   <= tag_q.irq;
          ret_valid <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R4
  ret_single_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> !ret_valid);
endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
  import stkp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic                push_req,
  input  logic [DATA_W-1:0]   push_data,
  input  logic                pop_req,
  input  logic                call_req,
  input  logic                irq_req,
  input  logic                ret_req,
  input  logic                iret_req,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   flags_in,
  input  logic                reg_wr_lo,
  input  logic                reg_wr_hi,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   mem_rd_data,
  output logic                mem_we,
  output logic                mem_re,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                stk_wrap,
  output logic                busy,
  output logic [DATA_W-1:0]   sp_lo,
  output logic [DATA_W-1:0]   sp_hi,
  output logic                pop_valid,
  output logic [DATA_W-1:0]   pop_data,
  output logic                ret_valid,
  output logic                ret_irq,
  output logic [DATA_W-1:0]   ret_flags,
  output logic [2*DATA_W-1:0] ret_pc
);
  localparam int SP_W = 2 * DATA_W;

  logic              hold, step_push, step_pop, wrap_push, wrap_pop;
  logic [DATA_W-1:0] step_byte;
  logic [SP_W-1:0]   push_addr, pop_addr, sp_view, pop_next;
  tag_t              step_tag, tag_q1;

  assign hold = reg_wr_lo || reg_wr_hi;

  stkp_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst(rst),
    .push_req(push_req), .pop_req(pop_req), .call_req(call_req),
    .irq_req(irq_req), .ret_req(ret_req), .iret_req(iret_req),
    .hold(hold), .push_data(push_data), .flags_in(flags_in), .pc_in(pc_in),
    .busy(busy), .step_push(step_push), .step_pop(step_pop),
    .step_byte(step_byte), .step_tag(step_tag)
  );

  stkp_ptr #(.DATA_W(DATA_W)) ptr_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .step_push(step_push), .step_pop(step_pop),
    .wr_lo(reg_wr_lo), .wr_hi(reg_wr_hi), .wdata(reg_wdata),
    .sp_lo(sp_lo), .sp_hi(sp_hi),
    .push_addr(push_addr), .pop_addr(pop_addr),
    .wrap_push(wrap_push), .wrap_pop(wrap_pop)
  );

  stkp_ret #(.DATA_W(DATA_W)) ret_i (
    .clk(clk), .rst(rst), .tag_in(tag_q1), .rd_data(mem_rd_data),
    .pop_valid(pop_valid), .pop_data(pop_data),
    .ret_valid(ret_valid), .ret_irq(ret_irq),
    .ret_flags(ret_flags), .ret_pc(ret_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      stk_wrap  <= 1'b0;
      tag_q1    <= '{irq: 1'b0, dst: DST_NONE};
    end else begin
      mem_we   <= step_push;
      mem_re   <= step_pop;
      stk_wrap <= (step_push && wrap_push) || (step_pop && wrap_pop);
      tag_q1   <= step_pop ? step_tag : '{irq: 1'b0, dst: DST_NONE};
      if (step_push) begin
        mem_addr  <= push_addr;
        mem_wdata <= step_byte;
      end else if (step_pop) begin
        mem_addr <= pop_addr;
      end
    end
  end

  assign sp_view  = wide_mode ? {sp_hi, sp_lo} : {{DATA_W{1'b0}}, sp_lo};
  assign pop_next = wide_mode ? (mem_addr + SP_W'(1))
                              : {{DATA_W{1'b0}}, mem_addr[DATA_W-1:0] + DATA_W'(1)};

  // R2
  tos_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp_view));

  // R3
  pop_incr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (sp_view == pop_next));

  // R6
  bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_we || mem_re) && !wide_mode) |-> (mem_addr[SP_W-1:DATA_W] == '0));

  // R9
  wr_priority_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!mem_we && !mem_re));
endmodule

// File: tb/stack_ptr_engine_tb_top.sv
`timescale 1ns/1ps
module stack_ptr_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b1;
  logic        push_req = 0, pop_req = 0, call_req = 0, irq_req = 0, ret_req = 0, iret_req = 0;
  logic [7:0]  push_data = 0, flags_in = 0, reg_wdata = 0, mem_rd_data;
  logic [15:0] pc_in = 0;
  logic        reg_wr_lo = 0, reg_wr_hi = 0;
  logic        mem_we, mem_re, stk_wrap, busy, pop_valid, ret_valid, ret_irq;
  logic [15:0] mem_addr, ret_pc;
  logic [7:0]  mem_wdata, sp_lo, sp_hi, pop_data, ret_flags;

  always #5 clk = ~clk;

  stack_ptr_engine #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .call_req(call_req), .irq_req(irq_req), .ret_req(ret_req), .iret_req(iret_req),
    .pc_in(pc_in), .flags_in(flags_in),
    .reg_wr_lo(reg_wr_lo), .reg_wr_hi(reg_wr_hi), .reg_wdata(reg_wdata),
    .mem_rd_data(mem_rd_data),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stk_wrap(stk_wrap), .busy(busy), .sp_lo(sp_lo), .sp_hi(sp_hi),
    .pop_valid(pop_valid), .pop_data(pop_data),
    .ret_valid(ret_valid), .ret_irq(ret_irq), .ret_flags(ret_flags), .ret_pc(ret_pc)
  );

  // synchronous RAM model, one cycle read latency
  logic [7:0] ram [0:1023];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    mem_rd_data <= ram[mem_addr[9:0]];
  end

  int checks = 0, failures = 0;
  int n_we = 0, n_wrap = 0, n_retv = 0;
  logic [15:0] last_wa = 0, last_ra = 0, got_pc = 0;
  logic [7:0]  got_pop = 0, got_flg = 0;
  logic        got_irq = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin n_we++; last_wa = mem_addr; end
      if (mem_re) last_ra = mem_addr;
      if (stk_wrap) n_wrap++;
      if (pop_valid) got_pop = pop_data;
      if (ret_valid) begin n_retv++; got_pc = ret_pc; got_flg = ret_flags; got_irq = ret_irq; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op codes: 0 push, 1 pop, 2 call, 3 irq, 4 ret, 5 iret
  task automatic run_op(input int op, input logic [15:0] arg, input logic [7:0] flg);
    @(negedge clk);
    push_data = arg[7:0]; pc_in = arg; flags_in = flg;
    push_req = (op == 0); pop_req = (op == 1); call_req = (op == 2);
    irq_req = (op == 3); ret_req = (op == 4); iret_req = (op == 5);
    @(negedge clk);
    {push_req, pop_req, call_req, irq_req, ret_req, iret_req} = '0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_sp(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    reg_wr_hi = 1; reg_wr_lo = 1; reg_wdata = hi;
    reg_wr_lo = 0;
    @(negedge clk);
    reg_wr_hi = 0; reg_wr_lo = 1; reg_wdata = lo;
    @(negedge clk);
    reg_wr_lo = 0;
  endtask

  // {op[2:0], arg[15:0], flg[7:0], exp_sp[15:0], exp_val[15:0], exp_flg[7:0]}
  localparam logic [66:0] VEC [0:5] = '{
    {3'd0, 16'h00A5, 8'h00, 16'h00FF, 16'h00A5, 8'h00},
    {3'd2, 16'h1234, 8'h00, 16'h00FD, 16'h0012, 8'h00},
    {3'd3, 16'hBEEF, 8'h5A, 16'h00FA, 16'h005A, 8'h00},
    {3'd5, 16'h0000, 8'h00, 16'h00FD, 16'hBEEF, 8'h5A},
    {3'd4, 16'h0000, 8'h00, 16'h00FF, 16'h1234, 8'h00},
    {3'd1, 16'h0000, 8'h00, 16'h0100, 16'h00A5, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired, all requirements unverified");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", {sp_hi, sp_lo}, 32'h0000);
    chk("R1 strobes", {busy, mem_we, mem_re, stk_wrap, pop_valid, ret_valid}, 32'h0);

    // table walk in wide mode
    wide_mode = 1;
    set_sp(8'h01, 8'h00);
    chk("R7 direct write", {sp_hi, sp_lo}, 32'h0100);
    for (int i = 0; i < 6; i++) begin
      logic [2:0]  op;
      logic [15:0] arg, esp, ev;
      logic [7:0]  fl, ef;
      {op, arg, fl, esp, ev, ef} = VEC[i];
      run_op(int'(op), arg, fl);
      chk("R7 pointer after op", {sp_hi, sp_lo}, esp);
      case (op)
        3'd0: chk("R2 top byte", ram[esp[9:0]], ev);
        3'd2: chk("R4 pc high on top", ram[esp[9:0]], ev);
        3'd3: chk("R5 flags on top", ram[esp[9:0]], ev);
        3'd1: chk("R3 popped byte", got_pop, ev);
        3'd4: chk("R4 ret pc", {got_irq, got_pc}, {1'b0, ev});
        3'd5: chk("R5 iret pc flags", {got_irq, got_flg, got_pc}, {1'b1, ef, ev});
        default: ;
      endcase
    end
    chk("R4 call low byte below top", ram[10'h0FE], 8'h34);
    chk("R5 irq pc bytes", {ram[10'h0FC], ram[10'h0FB]}, 16'hEFBE);
    chk("R4 one pulse per return", n_retv, 2);

    // R6 / R8 narrow mode with wrap
    wide_mode = 0;
    set_sp(8'h77, 8'h01);
    n_wrap = 0;
    run_op(0, 16'h0011, 8'h00);
    chk("R6 narrow push addr", last_wa, 16'h0000);
    chk("R8 no wrap at 01", n_wrap, 0);
    run_op(0, 16'h0022, 8'h00);
    chk("R6 narrow wrap addr bank0", last_wa, 16'h00FF);
    chk("R6 sp narrow and user byte kept", {sp_hi, sp_lo}, 16'h77FF);
    chk("R8 narrow push wrap", n_wrap, 1);
    run_op(1, 16'h0, 8'h00);
    chk("R3 narrow pop", got_pop, 8'h22);
    chk("R6 narrow pop addr", last_ra, 16'h00FF);
    chk("R8 narrow pop wrap", n_wrap, 2);
    run_op(1, 16'h0, 8'h00);
    chk("R3 second pop", {got_pop, sp_hi, sp_lo}, 24'h117701);

    // R7 / R8 wide wrap
    wide_mode = 1;
    set_sp(8'h00, 8'h00);
    n_wrap = 0;
    run_op(0, 16'h0033, 8'h00);
    chk("R8 wide push wrap addr", last_wa, 16'hFFFF);
    chk("R8 wide push wrap flag", {n_wrap[7:0], sp_hi, sp_lo}, 24'h01FFFF);
    run_op(1, 16'h0, 8'h00);
    chk("R8 wide pop wrap", {got_pop, n_wrap[7:0], sp_hi, sp_lo}, 32'h33020000);

    // R9 direct write beats push in same cycle
    set_sp(8'h02, 8'h00);
    begin
      int we_before;
      we_before = n_we;
      @(negedge clk);
      push_req = 1; push_data = 8'hEE; reg_wr_lo = 1; reg_wdata = 8'h40;
      @(negedge clk);
      push_req = 0; reg_wr_lo = 0;
      chk("R9 request discarded", busy, 1'b0);
      repeat (4) @(negedge clk);
      chk("R9 write applied", {sp_hi, sp_lo}, 16'h0240);
      chk("R9 no memory write", n_we - we_before, 0);
    end

    // R10 interrupt wins over push
    set_sp(8'h02, 8'h00);
    @(negedge clk);
    irq_req = 1; push_req = 1; pc_in = 16'hCAFE; flags_in = 8'h81; push_data = 8'h99;
    @(negedge clk);
    irq_req = 0; push_req = 0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 irq accepted", {sp_hi, sp_lo}, 16'h01FD);
    chk("R10 flags on top", ram[10'h1FD], 8'h81);
    run_op(5, 16'h0, 8'h00);
    chk("R10 iret restores", {got_irq, got_flg, got_pc, sp_hi, sp_lo}, {1'b1, 8'h81, 16'hCAFE, 16'h0200});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule